// File: doc/BRIEF.md
# APB Paged Register Window Bridge

This block is an APB slave that lets a host reach a 21-bit space of 16-bit management registers. A target address holds a 5-bit device field in bits [20:16] and a 16-bit register number in bits [15:0]. On the far side the bridge drives a plain synchronous register-file port. That port carries an address, write data, a write strobe and a read strobe, and it returns read data one clock after the read strobe.

The mode is fixed at build time by the parameter `INDIRECT`. In direct mode the bus index, which is the bus address divided by the register stride, is the target address itself. In indirect mode the host sees a window of 256 slots. The slot at the top of the window holds a page register. The page register supplies target bits [20:8], and the other slots supply bits [7:0]. The same bus address therefore reaches a different register after each page change. The register stride on the bus is 2 or 4 bytes, set by `STRIDE`.

Each transfer uses a setup cycle and two access cycles. In the first access cycle the downstream strobe fires for exactly one cycle. In the second access cycle PREADY is high, and PSLVERR and PRDATA are valid.

Top module: `apb_page_bridge`

## Requirements
- R1: After synchronous reset, pready, pslverr, rf_we and rf_re are low and the page register holds zero, so a page read returns 0.
- R2: A setup cycle (psel=1, penable=0) is followed by access cycle one, where pready=0 and at most one of rf_we/rf_re is high. Access cycle two follows, where pready=1 for that one cycle only.
- R3: In the ready cycle of an error-free read of a register-file slot, prdata[15:0] equals the rf_rdata value returned for the strobed address. prdata[31:16] is zero. For writes and errored transfers, prdata is zero.
- R4: A forwarded write drives rf_wdata with pwdata[15:0]. pwdata[31:16] has no effect.
- R5: An address whose low log2(STRIDE) bits are not zero gives pslverr=1 and raises no strobe.
- R6: Direct mode: index = paddr / STRIDE. rf_addr equals index[20:0], so the device field is rf_addr[20:16] and the register number is rf_addr[15:0].
- R7: Direct mode: an index of 2^21 or more gives pslverr=1 and raises no strobe.
- R8: Indirect mode: window slots 0x00..0xFE strobe rf_addr = {page, slot}, with the page in bits [20:8].
- R9: Indirect mode: slot 0xFF is the page register. A write loads pwdata[12:0] into it and raises no strobe. A read returns the page zero-extended and raises no strobe.
- R10: Indirect mode: a window index of 256 or more gives pslverr=1 and raises no strobe.
- R11: A page write applies to the very next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | PDATA_W | APB write data |
| prdata | output | PDATA_W | APB read data, valid with pready |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error (misaligned or out of range) |
| rf_addr | output | 21 | Register-file target address |
| rf_wdata | output | 16 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_rdata | input | 16 | Register-file read data, one cycle after rf_re |

## Verification
Two instances receive the same bus traffic: an indirect instance with a 4-byte stride and a direct instance with a 2-byte stride. Because of this, one address pattern can separate the two decodes. Random addresses inside the window check page concatenation against linear mapping. Full-width random addresses reach the out-of-range paths. Odd and half-stride addresses separate misalignment from range errors. Directed page writes followed by reads show that the page applies on the next transfer, that the write never reaches the register file, and that the upper write-data half is dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  parameter int unsigned PGW_TGT_AW = 21;
  parameter int unsigned PGW_OFF_W  = 8;
  parameter int unsigned PGW_PAGE_W = PGW_TGT_AW - PGW_OFF_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} pgw_state_e;
  typedef enum logic [1:0] {RS_NONE, RS_RF, RS_VP} pgw_rsel_e;

  typedef struct packed {
    logic                  err;
    logic                  vp_hit;
    logic [PGW_TGT_AW-1:0] tgt;
  } pgw_dec_t;
endpackage

// File: rtl/pgw_decode.sv
module pgw_decode
  import pgw_pkg::*;
#(
  parameter bit          INDIRECT = 1'b1,
  parameter int unsigned STRIDE   = 2,
  parameter int unsigned PADDR_W  = 24
) (
  input  logic [PADDR_W-1:0]    paddr,
  input  logic [PGW_PAGE_W-1:0] vp,
  output pgw_dec_t              dec
);
  localparam int unsigned SH    = (STRIDE == 4) ? 2 : 1;
  localparam int unsigned IDX_W = PADDR_W - SH;

  logic             misalign;
  logic [IDX_W-1:0] idx;

  assign misalign = |paddr[SH-1:0];
  assign idx      = paddr[PADDR_W-1:SH];

  generate
    if (INDIRECT) begin : g_ind
      localparam int unsigned EXT_W = (IDX_W > PGW_OFF_W) ? IDX_W : PGW_OFF_W + 1;
      logic [EXT_W-1:0]     ext;
      logic [PGW_OFF_W-1:0] slot;
      logic                 oor;
      assign ext  = EXT_W'(idx);
      assign slot = ext[PGW_OFF_W-1:0];
      assign oor  = |ext[EXT_W-1:PGW_OFF_W];
      assign dec.err    = misalign | oor;
      assign dec.vp_hit = (slot == '1);
      assign dec.tgt    = {vp, slot};
    end else begin : g_dir
      localparam int unsigned EXT_W = (IDX_W > PGW_TGT_AW) ? IDX_W : PGW_TGT_AW + 1;
      logic [EXT_W-1:0] ext;
      logic             oor;
      logic             unused_vp;
      assign ext       = EXT_W'(idx);
      assign oor       = |ext[EXT_W-1:PGW_TGT_AW];
      assign unused_vp = ^vp;
      assign dec.err    = misalign | oor;
      assign dec.vp_hit = 1'b0;
      assign dec.tgt    = ext[PGW_TGT_AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/pgw_viewport.sv
module pgw_viewport #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] vp
);
  always_ff @(posedge clk) begin
    if (rst)        vp <= '0;
    else if (wr_en) vp <= wr_val;
  end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [REG_W-1:0]      wdata,
  input  pgw_dec_t              dec,
  output logic [PGW_TGT_AW-1:0] rf_addr,
  output logic [REG_W-1:0]      rf_wdata,
  output logic                  rf_we,
  output logic                  rf_re,
  output logic                  vp_we,
  output logic                  pready,
  output logic                  pslverr,
  output pgw_rsel_e             rsel
);
  pgw_state_e st;
  logic       err_q;
  logic       setup;
  logic       fwd;

  assign setup = (st == ST_IDLE) && psel && !penable;
  assign fwd   = !dec.err && !dec.vp_hit;
  assign vp_we = setup && pwrite && !dec.err && dec.vp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      err_q    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      rf_we    <= 1'b0;
      rf_re    <= 1'b0;
      pready   <= 1'b0;
      pslverr  <= 1'b0;
      rsel     <= RS_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (setup) begin
            st       <= ST_ISSUE;
            err_q    <= dec.err;
            rf_addr  <= dec.tgt;
            rf_wdata <= wdata;
            rf_we    <= pwrite && fwd;
            rf_re    <= !pwrite && fwd;
            if (pwrite || dec.err) rsel <= RS_NONE;
            else if (dec.vp_hit)   rsel <= RS_VP;
            else                   rsel <= RS_RF;
          end
        end
        ST_ISSUE: begin
          rf_we   <= 1'b0;
          rf_re   <= 1'b0;
          pready  <= 1'b1;
          pslverr <= err_q;
          st      <= ST_DONE;
        end
        ST_DONE: begin
          pready  <= 1'b0;
          pslverr <= 1'b0;
          rsel    <= RS_NONE;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apb_page_bridge.sv
module apb_page_bridge
  import pgw_pkg::*;
#(
  parameter bit          INDIRECT = 1'b1,
  parameter int unsigned STRIDE   = 2,
  parameter int unsigned PADDR_W  = 24,
  parameter int unsigned PDATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [PADDR_W-1:0]    paddr,
  input  logic [PDATA_W-1:0]    pwdata,
  output logic [PDATA_W-1:0]    prdata,
  output logic                  pready,
  output logic                  pslverr,
  output logic [PGW_TGT_AW-1:0] rf_addr,
  output logic [15:0]           rf_wdata,
  output logic                  rf_we,
  output logic                  rf_re,
  input  logic [15:0]           rf_rdata
);
  localparam int unsigned REG_W = 16;

  pgw_dec_t              dec;
  logic [PGW_PAGE_W-1:0] vp;
  logic                  vp_we;
  pgw_rsel_e             rsel;
  logic                  unused_hi;

  assign unused_hi = ^pwdata[PDATA_W-1:REG_W];

  pgw_decode #(
    .INDIRECT(INDIRECT), .STRIDE(STRIDE), .PADDR_W(PADDR_W)
  ) u_dec (
    .paddr(paddr), .vp(vp), .dec(dec)
  );

  pgw_viewport #(.W(PGW_PAGE_W)) u_vp (
    .clk(clk), .rst(rst), .wr_en(vp_we),
    .wr_val(pwdata[PGW_PAGE_W-1:0]), .vp(vp)
  );

  pgw_seq #(.REG_W(REG_W)) u_seq (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .wdata(pwdata[REG_W-1:0]), .dec(dec),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
    .vp_we(vp_we), .pready(pready), .pslverr(pslverr), .rsel(rsel)
  );

  always_comb begin
    prdata = '0;
    if (pready) begin
      case (rsel)
        RS_RF:   prdata = PDATA_W'(rf_rdata);
        RS_VP:   prdata = PDATA_W'(vp);
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pgw_checks.sv
module pgw_checks (
  input logic        clk,
  input logic        rst,
  input logic        psel,
  input logic        penable,
  input logic        paddr_lsb,
  input logic        pready,
  input logic        pslverr,
  input logic        rf_we,
  input logic        rf_re,
  input logic [12:0] vp
);
  a_r2_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pready |=> !pready);

  a_r2_strobe_then_ready: assert property (@(posedge clk) disable iff (rst)
    (rf_we || rf_re) |=> pready);

  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && rf_re));

  a_r5_err_only_with_ready: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> pready);

  a_r5_misaligned_blocked: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pready && paddr_lsb) |=> !(rf_we || rf_re));

  a_r9_page_write_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    !$stable(vp) |-> !(rf_we || rf_re));
endmodule

bind apb_page_bridge pgw_checks u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable),
  .paddr_lsb(paddr[0]), .pready(pready), .pslverr(pslverr),
  .rf_we(rf_we), .rf_re(rf_re), .vp(vp)
);

// File: tb/sim_apb_page_bridge.sv
module sim_apb_page_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [23:0] paddr = '0;
  logic [31:0] pwdata = '0;

  logic [31:0] prd0, prd1;
  logic        rdy0, rdy1, err0, err1;
  logic [20:0] ad0, ad1;
  logic [15:0] wd0, wd1;
  logic        we0, we1, re0, re1;
  logic [15:0] rd0 = '0, rd1 = '0;

  int checks = 0;
  int fails  = 0;
  logic [12:0] vp_m = '0;

  always #5 clk = ~clk;

  // u0: indirect, 4-byte stride; u1: direct, 2-byte stride
  apb_page_bridge #(.INDIRECT(1'b1), .STRIDE(4)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd0), .pready(rdy0), .pslverr(err0),
    .rf_addr(ad0), .rf_wdata(wd0), .rf_we(we0), .rf_re(re0), .rf_rdata(rd0));

  apb_page_bridge #(.INDIRECT(1'b0), .STRIDE(2)) u1 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd1), .pready(rdy1), .pslverr(err1),
    .rf_addr(ad1), .rf_wdata(wd1), .rf_we(we1), .rf_re(re1), .rf_rdata(rd1));

  function automatic logic [15:0] rfval(input logic [20:0] a);
    return a[15:0] ^ {a[20:16], a[20:16], a[20:16], 1'b1};
  endfunction

  // register-file models: one-cycle read latency
  always @(posedge clk) begin
    if (re0) rd0 <= rfval(ad0);
    if (re1) rd1 <= rfval(ad1);
  end

  // kind: 0 register file, 1 page register, 2 misaligned, 3 out of range
  function automatic void model(input bit ind, input logic [23:0] a, input logic [12:0] v,
                                output int kind, output logic [20:0] t);
    logic [22:0] idx;
    t = '0;
    if (ind) begin
      idx = {1'b0, a[23:2]};
      if (a[1:0] != 0)      kind = 2;
      else if (idx >= 256)  kind = 3;
      else if (idx[7:0] == 8'hFF) kind = 1;
      else begin kind = 0; t = {v, idx[7:0]}; end
    end else begin
      idx = a[23:1];
      if (a[0])                   kind = 2;
      else if (idx >= 23'h200000) kind = 3;
      else begin kind = 0; t = idx[20:0]; end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic judge(input bit ind, input bit w, input logic [31:0] d, input int kind,
                       input logic [20:0] t, input logic [12:0] v, input string ov,
                       input logic s_we, input logic s_re, input logic [20:0] s_ad,
                       input logic [15:0] s_wd, input logic s_rdy1,
                       input logic s_rdy, input logic s_err, input logic [31:0] s_prd);
    string tg;
    logic [31:0] exp_rd;
    bit fwd;
    if (kind == 2)      tg = "R5";
    else if (kind == 3) tg = ind ? "R10" : "R7";
    else if (kind == 1) tg = "R9";
    else                tg = ind ? "R8" : "R6";
    if (ov != "") tg = ov;
    fwd = (kind == 0);
    check(s_rdy1 == 1'b0, "R2", "pready in first access cycle", {31'b0, s_rdy1}, 0);
    check(s_we == (fwd && w), tg, "rf_we", {31'b0, s_we}, {31'b0, fwd && w});
    check(s_re == (fwd && !w), tg, "rf_re", {31'b0, s_re}, {31'b0, fwd && !w});
    if (fwd) check(s_ad == t, tg, "rf_addr", {11'b0, s_ad}, {11'b0, t});
    if (fwd && w) check(s_wd == d[15:0], tg, "rf_wdata", {16'b0, s_wd}, {16'b0, d[15:0]});
    check(s_rdy == 1'b1, "R2", "pready in second access cycle", {31'b0, s_rdy}, 1);
    check(s_err == (kind >= 2), tg, "pslverr", {31'b0, s_err}, {31'b0, kind >= 2});
    exp_rd = '0;
    if (!w && kind == 0) exp_rd = {16'b0, rfval(t)};
    if (!w && kind == 1) exp_rd = {19'b0, v};
    check(s_prd == exp_rd, (kind == 0) ? "R3" : tg, "prdata", s_prd, exp_rd);
  endtask

  task automatic xfer(input bit w, input logic [23:0] a, input logic [31:0] d, input string ov);
    int k0, k1;
    logic [20:0] t0, t1;
    logic s_we0, s_re0, s_we1, s_re1, r10, r11;
    logic [20:0] s_ad0, s_ad1;
    logic [15:0] s_wd0, s_wd1;
    model(1'b1, a, vp_m, k0, t0);
    model(1'b0, a, 13'd0, k1, t1);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    s_we0 = we0; s_re0 = re0; s_ad0 = ad0; s_wd0 = wd0; r10 = rdy0;
    s_we1 = we1; s_re1 = re1; s_ad1 = ad1; s_wd1 = wd1; r11 = rdy1;
    @(negedge clk);
    judge(1'b1, w, d, k0, t0, vp_m, ov, s_we0, s_re0, s_ad0, s_wd0, r10, rdy0, err0, prd0);
    judge(1'b0, w, d, k1, t1, 13'd0, ov, s_we1, s_re1, s_ad1, s_wd1, r11, rdy1, err1, prd1);
    if (w && k0 == 1) vp_m = d[12:0];
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] a;
    int sel;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!rdy0 && !err0 && !we0 && !re0, "R1", "u0 idle outputs",
          {28'b0, rdy0, err0, we0, re0}, 0);
    check(!rdy1 && !err1 && !we1 && !re1, "R1", "u1 idle outputs",
          {28'b0, rdy1, err1, we1, re1}, 0);
    xfer(1'b0, 24'h0003FC, 32'h0, "R1");           // page reads zero after reset
    xfer(1'b1, 24'h0003FC, 32'hFFFF_1ABC, "R4");   // page write; upper half dropped
    xfer(1'b0, 24'h000040, 32'h0, "R11");          // next transfer uses new page
    xfer(1'b0, 24'h0003FC, 32'h0, "R9");           // page readback
    xfer(1'b1, 24'h000041, 32'h1234_5678, "R5");   // odd address
    xfer(1'b0, 24'h000402, 32'h0, "");             // half-stride for u0, out-of-window
    xfer(1'b0, 24'h400000, 32'h0, "");             // beyond 21-bit space
    xfer(1'b0, 24'h3FFFFE, 32'h0, "R6");           // top of direct space
    xfer(1'b1, 24'h000100, 32'hA5A5_C3C3, "R8");
    xfer(1'b1, 24'h0003FC, 32'h0000_0000, "R11");
    xfer(1'b0, 24'h000008, 32'h0, "R11");
    for (int i = 0; i < 400; i++) begin
      sel = int'($urandom % 4);
      case (sel)
        0:       a = {14'b0, 10'($urandom)};
        1:       a = 24'h0003FC;
        2:       a = 24'($urandom);
        default: a = {2'b0, 20'($urandom), 2'b00};
      endcase
      xfer(1'($urandom), a, $urandom, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule